// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Power-up Engine

This block keeps an asynchronous DRAM array alive without ever producing a refresh address. Each refresh uses the column-strobe-first ordering: the column strobes drop, then the row strobe drops, and the device's internal counter picks the row. After reset the engine waits out the power-up pause. It then runs a burst of eight refresh cycles to wake the array and raises `ready`. From then on it issues one refresh per interval tick, paced so that every row is covered within the retention period.

The engine shares the strobe pins with a data-access controller through a request/grant pair. It raises `refReq` whenever a refresh is owed. It starts a cycle only while `refGnt` is high. Once a cycle has started it completes it. It drops the request only after the row strobe has been high long enough to precharge. If the grant is withheld across several ticks, the missed refreshes are counted up to a small ceiling and then run back to back. All time limits are given in nanoseconds and turned into clock cycles from a clock-period parameter. Each is rounded up.

Top module: `cbr_refresh_engine`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rasN`=1, every bit of `casN`=1, `weN`=1, `refReq`=0 and `ready`=0.
- R2: No falling edge of `rasN` occurs sooner than ceil(200 us / clock period) cycles after reset is released (20000 at 10 ns).
- R3: After the pause, exactly 8 refresh cycles take place with `ready`=0. `ready` is 1 at the next refresh and stays 1 until reset.
- R4: While the grant is held after `ready`, consecutive `rasN` falling edges are exactly ceil(15.6 us / clock period) cycles apart (1560 at 10 ns).
- R5: In every refresh, all `casN` bits are 0 for at least ceil(5 ns / period) cycles before `rasN` falls.
- R6: `casN` stays 0 for at least ceil(10 ns / period) cycles after `rasN` falls.
- R7: `rasN` has been 1 for at least ceil(5 ns / period) cycles when `casN` falls.
- R8: `weN` is 1 at every refresh and at every other time.
- R9: Refreshes issued back to back, during the power-up burst or when working off owed refreshes, have falling edges of `rasN` exactly ceil(90 ns / period) cycles apart (9 at 10 ns).
- R10: Ticks that pass while the grant is low each add one owed refresh, up to a ceiling of 4. On the grant, exactly min(missed, 4) refreshes run back to back and no others follow before the next tick.
- R11: `rasN` never falls unless `refGnt` has been high for the 3 preceding cycles. `refReq` stays 1 while a refresh is owed. `refReq` falls only when `rasN` has been 1 for at least ceil(5 ns / period) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGnt | input | 1 | Grant of the strobe pins from the access controller |
| refReq | output | 1 | Request for the strobe pins |
| rasN | output | 1 | Row strobe, active low |
| casN | output | CAS_W | Column strobes, active low, all driven alike |
| weN | output | 1 | Write enable, active low, held high |
| ready | output | 1 | Power-up sequence finished |

## Verification
The bench targets four behaviours.

- **Power-up boundary:** it checks the cycle of the first row-strobe fall against the pause and the exact count of refreshes made before `ready`. An engine that counted the pause short, or raised `ready` after seven or nine cycles, would misalign the expected `ready` value at one of the refreshes.
- **Owed-refresh counter:** the grant is withheld across three ticks and then across six. A counter that lost a tick would under-deliver, and one without a ceiling would run a fifth or sixth refresh that nothing expects. A wrong back-to-back gap also shows up in the exact spacing check.
- **Strobe ordering:** every refresh is checked for column-first order, column hold, precharge before the column fall and write enable high. Inverted or merged edges fail these checks at once.
- **Grant handling:** the bench watches for any row-strobe fall without a standing grant.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_PRE,
    ST_CASLO,
    ST_RASLO,
    ST_RECOVER
  } cbrState_t;

  typedef struct packed {
    logic rowLow;
    logic colLow;
    logic reqOn;
  } cbrStrobe_t;

  function automatic int nsToCyc(input int ns, input int clkPs);
    int c;
    c = (ns * 1000 + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int INIT_NS     = 200000,
  parameter int INTERVAL_NS = 15600,
  parameter int INIT_BURST  = 8,
  parameter int MAX_OWED    = 4,
  parameter int T_CSR_NS    = 5,
  parameter int T_CHR_NS    = 10,
  parameter int T_RPC_NS    = 5,
  parameter int T_RAS_NS    = 50,
  parameter int T_RC_NS     = 90
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGnt,
  output cbrStrobe_t strobe,
  output logic       ready
);

  localparam int INIT_CYC     = nsToCyc(INIT_NS, CLK_PS);
  localparam int INTERVAL_CYC = nsToCyc(INTERVAL_NS, CLK_PS);
  localparam int CSR_CYC      = nsToCyc(T_CSR_NS, CLK_PS);
  localparam int RPC_CYC      = nsToCyc(T_RPC_NS, CLK_PS);
  localparam int ACT_CYC      = maxOf(nsToCyc(T_CHR_NS, CLK_PS), nsToCyc(T_RAS_NS, CLK_PS));
  localparam int REC_CYC      = maxOf(maxOf(nsToCyc(T_RC_NS, CLK_PS) - ACT_CYC - CSR_CYC, RPC_CYC), 1);
  localparam int PEND_MAX     = maxOf(INIT_BURST, MAX_OWED);
  localparam int PEND_W       = $clog2(PEND_MAX + 1);
  localparam int PH_W         = $clog2(maxOf(INIT_CYC, ACT_CYC + REC_CYC) + 1);
  localparam int TMR_W        = $clog2(INTERVAL_CYC + 1);

  cbrState_t         state, stateNext;
  logic [PH_W-1:0]   phase, phaseLast;
  logic              phaseEnd;
  logic [PEND_W-1:0] pend, pendNext;
  logic [TMR_W-1:0]  tmr;
  logic              tick, done;

  always_comb begin
    case (state)
      ST_INIT:    phaseLast = PH_W'(INIT_CYC - 1);
      ST_PRE:     phaseLast = PH_W'(RPC_CYC - 1);
      ST_CASLO:   phaseLast = PH_W'(CSR_CYC - 1);
      ST_RASLO:   phaseLast = PH_W'(ACT_CYC - 1);
      ST_RECOVER: phaseLast = PH_W'(REC_CYC - 1);
      default:    phaseLast = '0;
    endcase
  end

  assign phaseEnd = (phase == phaseLast);
  assign tick     = ready && (tmr == TMR_W'(INTERVAL_CYC - 1));
  assign done     = (state == ST_RECOVER) && phaseEnd;

  // owed-refresh bookkeeping: load burst, retire on completion, add on tick
  always_comb begin
    pendNext = pend;
    if (state == ST_INIT && phaseEnd) begin
      pendNext = PEND_W'(INIT_BURST);
    end else begin
      if (done) pendNext = pend - PEND_W'(1);
      if (tick && pendNext < PEND_W'(MAX_OWED)) pendNext = pendNext + PEND_W'(1);
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_INIT:    if (phaseEnd) stateNext = ST_IDLE;
      ST_IDLE:    if (pend != '0 && refGnt) stateNext = ST_PRE;
      ST_PRE:     if (phaseEnd) stateNext = ST_CASLO;
      ST_CASLO:   if (phaseEnd) stateNext = ST_RASLO;
      ST_RASLO:   if (phaseEnd) stateNext = ST_RECOVER;
      ST_RECOVER: if (phaseEnd) stateNext = (pendNext != '0 && refGnt) ? ST_CASLO : ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_INIT;
      phase <= '0;
      pend  <= '0;
      tmr   <= '0;
      ready <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= (stateNext != state || state == ST_IDLE) ? '0 : phase + PH_W'(1);
      pend  <= pendNext;
      tmr   <= (!ready || tick) ? '0 : tmr + TMR_W'(1);
      ready <= ready | (done && pend == PEND_W'(1));
    end
  end

  always_comb begin
    strobe.rowLow = (state == ST_RASLO);
    strobe.colLow = (state == ST_CASLO) || (state == ST_RASLO);
    strobe.reqOn  = (pend != '0) || (state inside {ST_PRE, ST_CASLO, ST_RASLO, ST_RECOVER});
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN) ready |=> ready); // R3
  AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (!rstN) ready |-> (pend <= PEND_W'(MAX_OWED))); // R10
  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rstN) $rose(strobe.colLow) |-> $past(refGnt)); // R11

endmodule

// File: rtl/cbr_strobe_dp.sv
module cbr_strobe_dp
  import cbr_pkg::*;
#(
  parameter int CAS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cbrStrobe_t       strobe,
  output logic             rasN,
  output logic [CAS_W-1:0] casN,
  output logic             weN,
  output logic             refReq
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN   <= 1'b1;
      casN   <= '1;
      refReq <= 1'b0;
    end else begin
      rasN   <= ~strobe.rowLow;
      casN   <= {CAS_W{~strobe.colLow}};
      refReq <= strobe.reqOn;
    end
  end

  // refresh cycles never write
  assign weN = 1'b1;

  AST_CAS_LEAD: assert property (@(posedge clk) disable iff (!rstN) $fell(rasN) |-> ($past(casN) == '0)); // R5
  AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rstN) $rose(casN[0]) |-> ($past(rasN) == 1'b0)); // R6
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN) $fell(casN[0]) |-> (rasN && $past(rasN))); // R7
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN) $fell(refReq) |-> (rasN && $past(rasN))); // R11

endmodule

// File: rtl/cbr_refresh_engine.sv
module cbr_refresh_engine
  import cbr_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int INIT_NS     = 200000,
  parameter int INTERVAL_NS = 15600,
  parameter int INIT_BURST  = 8,
  parameter int MAX_OWED    = 4,
  parameter int T_CSR_NS    = 5,
  parameter int T_CHR_NS    = 10,
  parameter int T_RPC_NS    = 5,
  parameter int T_RAS_NS    = 50,
  parameter int T_RC_NS     = 90,
  parameter int CAS_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGnt,
  output logic             refReq,
  output logic             rasN,
  output logic [CAS_W-1:0] casN,
  output logic             weN,
  output logic             ready
);

  cbrStrobe_t strobe;

  cbr_ctrl #(
    .CLK_PS(CLK_PS), .INIT_NS(INIT_NS), .INTERVAL_NS(INTERVAL_NS),
    .INIT_BURST(INIT_BURST), .MAX_OWED(MAX_OWED), .T_CSR_NS(T_CSR_NS),
    .T_CHR_NS(T_CHR_NS), .T_RPC_NS(T_RPC_NS), .T_RAS_NS(T_RAS_NS), .T_RC_NS(T_RC_NS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .strobe(strobe), .ready(ready)
  );

  cbr_strobe_dp #(.CAS_W(CAS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rasN(rasN), .casN(casN), .weN(weN), .refReq(refReq)
  );

endmodule

// File: tb/tb_cbr_refresh_engine.sv
module tb_cbr_refresh_engine;

  localparam int CAS_W = 4;
  localparam int PER_PS = 10000;

  function automatic int cyc(input int ns);
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction

  localparam int INIT_CYC = cyc(200000);
  localparam int INT_CYC  = cyc(15600);
  localparam int RC_CYC   = cyc(90);
  localparam int CSR_CYC  = cyc(5);
  localparam int CHR_CYC  = cyc(10);
  localparam int RPC_CYC  = cyc(5);

  logic clk = 1'b0, rstN = 1'b0, refGnt = 1'b0;
  logic refReq, rasN, weN, ready;
  logic [CAS_W-1:0] casN;

  always #5ns clk = ~clk;

  cbr_refresh_engine #(.CAS_W(CAS_W)) dut (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .refReq(refReq),
    .rasN(rasN), .casN(casN), .weN(weN), .ready(ready)
  );

  typedef struct {
    string tag;
    bit    rdy;
    int    gap;
    bit    exact;
  } expItem_t;

  expItem_t q[$];
  int nChecks = 0, nFails = 0, fallCount = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input string tag, input bit rdy, input int gap, input bit exact);
    expItem_t e;
    e.tag = tag; e.rdy = rdy; e.gap = gap; e.exact = exact;
    q.push_back(e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: samples at the falling edge, compares refreshes against the queue
  int cycN = 0, lastFall = 0;
  int casLowRun = 0, rasHighRun = 0, rasLowRun = 0, gntRun = 0;
  logic prevRas = 1'b1, prevCasLow = 1'b0, prevReq = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic casLow = (casN == '0);
      cycN++;
      if (prevRas && !rasN) begin
        fallCount++;
        chk(casLowRun >= CSR_CYC, "R5", "cas lead cycles", casLowRun, CSR_CYC);
        chk(weN == 1'b1, "R8", "weN at refresh", int'(weN), 1);
        chk(gntRun >= 3, "R11", "grant cycles before ras fall", gntRun, 3);
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected refresh count", fallCount, fallCount - 1);
        end else begin
          automatic expItem_t e = q.pop_front();
          automatic int gap = cycN - lastFall;
          if (e.exact) chk(gap == e.gap, e.tag, "ras fall spacing", gap, e.gap);
          else         chk(gap >= e.gap, e.tag, "ras fall min spacing", gap, e.gap);
          chk(ready == e.rdy, e.tag, "ready at refresh", int'(ready), int'(e.rdy));
        end
        lastFall = cycN;
      end
      if (!prevCasLow && casLow)
        chk(rasN && rasHighRun >= RPC_CYC, "R7", "ras precharge before cas fall", rasHighRun, RPC_CYC);
      if (prevCasLow && !casLow)
        chk(rasLowRun >= CHR_CYC, "R6", "cas hold after ras fall", rasLowRun, CHR_CYC);
      if (prevReq && !refReq)
        chk(rasN && rasHighRun >= RPC_CYC, "R11", "ras high at request release", rasHighRun, RPC_CYC);
      casLowRun  = casLow ? casLowRun + 1 : 0;
      rasHighRun = rasN ? rasHighRun + 1 : 0;
      rasLowRun  = !rasN ? rasLowRun + 1 : 0;
      gntRun     = refGnt ? gntRun + 1 : 0;
      prevRas    = rasN;
      prevCasLow = casLow;
      prevReq    = refReq;
    end
  end

  // driver
  initial begin
    repeat (4) @(negedge clk);
    chk(rasN == 1'b1 && casN == '1, "R1", "strobes in reset", int'({rasN, casN}), 5'h1f);
    chk(weN == 1'b1 && refReq == 1'b0 && ready == 1'b0, "R1", "we/req/ready in reset",
        int'({weN, refReq, ready}), 3'b100);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(rasN == 1'b1 && casN == '1 && refReq == 1'b0 && ready == 1'b0, "R1", "first cycle after reset",
        int'({rasN, casN, refReq, ready}), 7'b1111100);

    // power-up: pause, 8-cycle burst, then periodic refreshes
    push("R2", 1'b0, INIT_CYC, 1'b0);
    for (int i = 0; i < 7; i++) push("R3 R9", 1'b0, RC_CYC, 1'b1);
    push("R3", 1'b1, RC_CYC, 1'b0);
    push("R4", 1'b1, INT_CYC, 1'b1);
    push("R4", 1'b1, INT_CYC, 1'b1);
    #1 refGnt = 1'b1;
    wait (q.size() == 0);

    // grant withheld across three ticks
    @(negedge clk); #1 refGnt = 1'b0;
    repeat (3 * INT_CYC + INT_CYC / 2) @(negedge clk);
    chk(refReq == 1'b1, "R11", "request held while owed", int'(refReq), 1);
    chk(rasN == 1'b1 && casN == '1, "R11", "strobes idle without grant", int'({rasN, casN}), 5'h1f);
    push("R10", 1'b1, RC_CYC, 1'b0);
    push("R9 R10", 1'b1, RC_CYC, 1'b1);
    push("R9 R10", 1'b1, RC_CYC, 1'b1);
    #1 refGnt = 1'b1;
    wait (q.size() == 0);
    repeat (2 * RC_CYC) @(negedge clk);
    chk(refReq == 1'b0, "R10", "request released after owed run", int'(refReq), 0);

    // grant withheld across six ticks: only four are kept
    #1 refGnt = 1'b0;
    repeat (6 * INT_CYC + INT_CYC / 2) @(negedge clk);
    push("R10", 1'b1, RC_CYC, 1'b0);
    for (int i = 0; i < 3; i++) push("R10", 1'b1, RC_CYC, 1'b1);
    #1 refGnt = 1'b1;
    wait (q.size() == 0);
    begin
      automatic int fc = fallCount;
      repeat (20 * RC_CYC) @(negedge clk);
      chk(fallCount == fc, "R10", "refreshes beyond ceiling", fallCount, fc);
    end
    chk(weN == 1'b1, "R8", "weN idle", int'(weN), 1);
    chk(ready == 1'b1, "R3", "ready stays high", int'(ready), 1);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R4 watchdog expired: actual %0d expected %0d", q.size(), 0);
    summary();
  end

endmodule